// File: doc/BRIEF.md
# Arbitrary-Length Full-Duplex SPI Master

This block is an SPI master that runs one full-duplex transfer of any length from a single bit up to the whole of its data buffer. The length does not have to be a multiple of eight. The CPU side fills a buffer of 32-bit words with the outgoing bits. It programs the length, which is the bit count minus one, and pulses a start strobe. While the transfer runs the block reports busy. Each received bit replaces, in the same buffer, the bit that was sent from that position. The CPU reads the results once busy drops.

The serial side works in SPI mode 0. SCLK idles low, MOSI changes on the falling edge and MISO is sampled on the rising edge. SCLK is derived from the system clock by a programmable half-period divider. A trailing partial byte is committed in full: its received bits go into the low positions of that byte, and the positions past the end of the transfer are cleared. This happens without any extra clock pulse, before busy is released. Stream bit i lives in bit i mod 32 of word i/32. Byte k of the stream therefore occupies bits 8(k mod 4)+7 down to 8(k mod 4) of word k/4, with the least significant bit travelling first.

Top module: `spi_fl_master`

## Requirements
- R1: With `xfer_len` = L, a transfer produces exactly L+1 SCLK rising edges. L can be any value from 0 to 511, which gives 1 to 512 bits.
- R2: SCLK is low whenever `cs_n` is high. MOSI changes only on a falling SCLK edge, or once before the first edge. MISO is sampled on the rising SCLK edge.
- R3: Stream bit i is sent from bit i mod 32 of buffer word i/32. Within each byte the least significant bit goes first.
- R4: The MISO value sampled on rising edge i is stored at bit i mod 32 of word i/32. Bits in bytes that the transfer never reached keep their earlier contents.
- R5: When L+1 is not a multiple of 8, the bit positions of the final byte beyond the transfer read 0 afterwards. For example, seven bits received as 0,1,0,0,0,0,0 leave that byte at 0x02, whatever it held before.
- R6: One SCLK half-period is `half_div`+1 system clocks. `cs_n` falls one half-period before the first rising edge and rises one half-period after the last falling edge.
- R7: `busy` rises in the cycle after an accepted start. It falls only after the final-byte write-back, so the buffer already holds the final data when `busy` is first seen low. `cs_n` is high while `busy` is low.
- R8: A start strobe while `busy` is high is ignored. The running transfer keeps its length, and no new transfer follows it.
- R9: While `busy` is high, CPU buffer writes are dropped and `cpu_rdata` reads 0.
- R10: A CPU write in the same cycle as an accepted start is committed, and the transfer sends the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_len | input | 9 | Bit count minus one, sampled at start |
| half_div | input | 8 | SCLK half-period in system clocks, minus one |
| start | input | 1 | Start strobe, one cycle |
| busy | output | 1 | Transfer in progress |
| cpu_we | input | 1 | Buffer word write enable |
| cpu_addr | input | 4 | Buffer word address |
| cpu_wdata | input | 32 | Buffer write data |
| cpu_rdata | output | 32 | Buffer read data (0 while busy) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
Two events can land in the same cycle: a CPU buffer write and the start strobe. The bench provokes this by raising `cpu_we` and `start` at one falling clock edge, with a fresh word for address 0. It judges the result from the MOSI bits captured by its slave model, which must carry the new word, and from the buffer read back afterwards. A second pairing issues a start strobe and a CPU write together in the middle of a transfer. There the bench checks that the SCLK pulse count, the buffer contents and the idle state after the transfer are all unaffected.

// File: rtl/spi_fl_pkg.sv
package spi_fl_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_RUN,
      ST_TRAIL,
      ST_FIX
   } seq_state_e;
endpackage

// File: rtl/spi_fl_tick.sv
// Half-period strobe: one tick every half_div+1 cycles while run is high.
module spi_fl_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (!run)            cnt <= half_div;
      else if (cnt == '0)       cnt <= half_div;
      else                      cnt <= cnt - 1'b1;
   end

   assign tick = run && (cnt == '0);
endmodule

// File: rtl/spi_fl_buf.sv
// Bit-addressable transfer buffer: CPU word port, serial bit read/write,
// and a one-cycle clear of the unused tail of the final byte.
module spi_fl_buf #(
   parameter int WORDS  = 16,
   parameter int WORD_W = 32,
   localparam int ADDR_W = $clog2(WORDS),
   localparam int BIT_W  = $clog2(WORD_W),
   localparam int LEN_W  = ADDR_W + BIT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic [WORD_W-1:0] cpu_word,
   input  logic [LEN_W-1:0]  rd_idx,
   output logic              tx_bit,
   input  logic              wr_en,
   input  logic [LEN_W-1:0]  wr_idx,
   input  logic              wr_val,
   input  logic              tail_en,
   input  logic [LEN_W-1:0]  last_idx
);
   logic [WORD_W-1:0] mem [WORDS];
   logic [WORD_W-1:0] tail_mask;
   logic [BIT_W-1:0]  last_bit;
   logic [ADDR_W-1:0] last_word;

   assign last_bit  = last_idx[BIT_W-1:0];
   assign last_word = last_idx[LEN_W-1:BIT_W];

   // A bit is cleared when it lies above the last transferred bit
   // but inside the same byte.
   for (genvar b = 0; b < WORD_W; b++) begin : g_mask
      assign tail_mask[b] = (BIT_W'(b) > last_bit) &&
                            ((BIT_W'(b) >> 3) == (last_bit >> 3));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      end else if (cpu_we) begin
         mem[cpu_addr] <= cpu_wdata;
      end else if (wr_en) begin
         mem[wr_idx[LEN_W-1:BIT_W]][wr_idx[BIT_W-1:0]] <= wr_val;
      end else if (tail_en) begin
         mem[last_word] <= mem[last_word] & ~tail_mask;
      end
   end

   assign tx_bit   = mem[rd_idx[LEN_W-1:BIT_W]][rd_idx[BIT_W-1:0]];
   assign cpu_word = mem[cpu_addr];
endmodule

// File: rtl/spi_fl_seq.sv
// Transfer sequencer: chip select, SCLK phases, bit index, write-back.
module spi_fl_seq
   import spi_fl_pkg::*;
#(
   parameter int LEN_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] xfer_len,
   input  logic             tick,
   input  logic             tx_bit,
   input  logic             miso,
   output logic             busy,
   output logic             run,
   output logic             sclk,
   output logic             mosi,
   output logic             cs_n,
   output logic [LEN_W-1:0] rd_idx,
   output logic             wr_en,
   output logic [LEN_W-1:0] wr_idx,
   output logic             wr_val,
   output logic             tail_en,
   output logic [LEN_W-1:0] last_idx
);
   seq_state_e       state;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] idx;
   logic             sclk_q, mosi_q, cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         len_q  <= '0;
         idx    <= '0;
         sclk_q <= 1'b0;
         mosi_q <= 1'b0;
         cs_q   <= 1'b1;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               len_q <= xfer_len;
               idx   <= '0;
               state <= ST_LOAD;
            end
            ST_LOAD: begin
               mosi_q <= tx_bit;
               cs_q   <= 1'b0;
               state  <= ST_RUN;
            end
            ST_RUN: if (tick) begin
               if (!sclk_q) begin
                  sclk_q <= 1'b1;
               end else begin
                  sclk_q <= 1'b0;
                  if (idx == len_q) begin
                     state <= ST_TRAIL;
                  end else begin
                     idx    <= idx + 1'b1;
                     mosi_q <= tx_bit;
                  end
               end
            end
            ST_TRAIL: if (tick) begin
               cs_q  <= 1'b1;
               state <= ST_FIX;
            end
            ST_FIX:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state != ST_IDLE);
   assign run      = (state == ST_RUN) || (state == ST_TRAIL);
   assign sclk     = sclk_q;
   assign mosi     = mosi_q;
   assign cs_n     = cs_q;
   assign rd_idx   = (state == ST_LOAD) ? idx : idx + LEN_W'(1);
   assign wr_en    = (state == ST_RUN) && tick && !sclk_q;
   assign wr_idx   = idx;
   assign wr_val   = miso;
   assign tail_en  = (state == ST_FIX);
   assign last_idx = len_q;
endmodule

// File: rtl/spi_fl_master.sv
module spi_fl_master #(
   parameter int BUF_WORDS = 16,
   parameter int WORD_W    = 32,
   parameter int DIV_W     = 8,
   localparam int ADDR_W   = $clog2(BUF_WORDS),
   localparam int BIT_W    = $clog2(WORD_W),
   localparam int LEN_W    = ADDR_W + BIT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEN_W-1:0]  xfer_len,
   input  logic [DIV_W-1:0]  half_div,
   input  logic              start,
   output logic              busy,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic              cs_n
);
   if (WORD_W < 8 || (WORD_W % 8) != 0 || (1 << BIT_W) != WORD_W) begin : g_bad_word
      $error("spi_fl_master: WORD_W must be a power of two and at least 8");
   end
   if (BUF_WORDS < 2 || (1 << ADDR_W) != BUF_WORDS) begin : g_bad_depth
      $error("spi_fl_master: BUF_WORDS must be a power of two and at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("spi_fl_master: DIV_W must be at least 1");
   end

   logic             tick, run, tx_bit;
   logic             wr_en, wr_val, tail_en;
   logic [LEN_W-1:0] rd_idx, wr_idx, last_idx;
   logic [WORD_W-1:0] cpu_word;

   spi_fl_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(run), .half_div(half_div), .tick(tick)
   );

   spi_fl_seq #(.LEN_W(LEN_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
      .tick(tick), .tx_bit(tx_bit), .miso(miso), .busy(busy), .run(run),
      .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .rd_idx(rd_idx),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
      .tail_en(tail_en), .last_idx(last_idx)
   );

   spi_fl_buf #(.WORDS(BUF_WORDS), .WORD_W(WORD_W)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .cpu_we(cpu_we && !busy), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_word(cpu_word), .rd_idx(rd_idx), .tx_bit(tx_bit),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
      .tail_en(tail_en), .last_idx(last_idx)
   );

   assign cpu_rdata = busy ? '0 : cpu_word;
endmodule

// File: rtl/spi_fl_chk.sv
module spi_fl_chk #(
   parameter int LEN_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [LEN_W-1:0] xfer_len,
   input logic             busy,
   input logic             sclk,
   input logic             mosi,
   input logic             cs_n
);
   logic [LEN_W-1:0] len_seen;
   logic [LEN_W:0]   rises;
   logic             sclk_d, cs_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_seen <= '0;
         rises    <= '0;
         sclk_d   <= 1'b0;
         cs_d     <= 1'b1;
      end else begin
         sclk_d <= sclk;
         cs_d   <= cs_n;
         if (start && !busy) begin
            len_seen <= xfer_len;
            rises    <= '0;
         end else if (sclk && !sclk_d) begin
            rises <= rises + 1'b1;
         end
      end
   end

   // R1
   pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && !cs_d) |-> (rises == {1'b0, len_seen} + (LEN_W+1)'(1)));

   // R2
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R2
   mosi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mosi) |-> ($fell(sclk) || $past(cs_n)));

   // R7
   idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs_n);

   // R7
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(cs_n) && !sclk));
endmodule

bind spi_fl_master spi_fl_chk #(.LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
   .busy(busy), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
);

// File: tb/spi_fl_master_test.sv
module spi_fl_master_test;
   localparam int NW = 16;
   localparam int TB = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [8:0]  xfer_len = '0;
   logic [7:0]  half_div = '0;
   logic        start = 1'b0;
   logic        busy;
   logic        cpu_we = 1'b0;
   logic [3:0]  cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        sclk, mosi, cs_n;
   logic        miso = 1'b0;

   always #4 clk = ~clk;

   spi_fl_master uut (
      .clk(clk), .rst_n(rst_n), .xfer_len(xfer_len), .half_div(half_div),
      .start(start), .busy(busy), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .sclk(sclk),
      .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0]   model [NW];
   logic [TB-1:0] rxpat = '0;
   logic [TB-1:0] txsnap = '0;
   logic [TB-1:0] cap = '0;
   int  pulses = 0;
   int  slv_i = 0;
   bit  first_r = 1'b0;
   time t_csf = 0, t_r1 = 0, t_lastf = 0, t_csr = 0;

   // slave model: mode 0
   always @(negedge cs_n) begin
      t_csf = $time; slv_i = 0; miso = rxpat[0]; first_r = 1'b1; pulses = 0;
   end
   always @(posedge sclk) begin
      if (first_r) begin t_r1 = $time; first_r = 1'b0; end
      if (pulses < TB) cap[pulses] = mosi;
      pulses++;
   end
   always @(negedge sclk) begin
      t_lastf = $time;
      slv_i++;
      if (slv_i < TB) miso = rxpat[slv_i];
   end
   always @(posedge cs_n) t_csr = $time;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cpu_wr(input int a, input logic [31:0] d);
      @(negedge clk);
      cpu_we = 1'b1; cpu_addr = 4'(a); cpu_wdata = d;
      @(negedge clk);
      cpu_we = 1'b0;
   endtask

   task automatic load_all();
      for (int w = 0; w < NW; w++) cpu_wr(w, model[w]);
   endtask

   // snapshot outgoing bits, then apply the expected receive effect to model
   task automatic prepare(input int n);
      for (int i = 0; i < TB; i++) txsnap[i] = model[i/32][i%32];
      for (int i = 0; i < n; i++) model[i/32][i%32] = rxpat[i];
      for (int b = n; (b % 8) != 0; b++) model[b/32][b%32] = 1'b0;
   endtask

   task automatic launch(input int n, input int d);
      @(negedge clk);
      xfer_len = 9'(n - 1); half_div = 8'(d); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      while (busy) @(negedge clk);
   endtask

   task automatic verify(input int n, input int d, input string tag);
      int miss;
      logic [31:0] rd;
      // R7: final word already correct when busy is first seen low
      cpu_addr = 4'((n - 1) / 32);
      #1;
      chk(cpu_rdata == model[(n-1)/32], {"R7 data ready at busy fall ", tag},
          cpu_rdata, model[(n-1)/32]);
      chk(pulses == n, {"R1 pulse count ", tag}, pulses, n);
      miss = 0;
      for (int i = 0; i < n; i++) if (cap[i] !== txsnap[i]) miss++;
      chk(miss == 0, {"R3 mosi bits ", tag}, miss, 0);
      chk((t_r1 - t_csf) == time'((d + 1) * 8), {"R6 lead ", tag},
          t_r1 - t_csf, (d + 1) * 8);
      chk((t_csr - t_lastf) == time'((d + 1) * 8), {"R6 trail ", tag},
          t_csr - t_lastf, (d + 1) * 8);
      for (int w = 0; w < NW; w++) begin
         @(negedge clk);
         cpu_addr = 4'(w);
         #1;
         rd = cpu_rdata;
         chk(rd === model[w], $sformatf("R4/R5 word %0d %s", w, tag), rd, model[w]);
      end
   endtask

   task automatic t_reset();
      cpu_addr = '0;
      #1;
      chk(busy == 1'b0, "R7 reset busy", busy, 0);
      chk(cs_n == 1'b1, "R7 reset cs_n", cs_n, 1);
      chk(sclk == 1'b0, "R2 reset sclk", sclk, 0);
      chk(cpu_rdata == 32'h0, "R9 reset rdata", cpu_rdata, 0);
   endtask

   task automatic t_len31();
      for (int w = 0; w < NW; w++) model[w] = 32'h9E37_79B9 * (w + 3);
      load_all();
      rxpat = {16{32'h5A3C_96E1}};
      prepare(31);
      launch(31, 1);
      wait_done();
      verify(31, 1, "len31");
   endtask

   task automatic t_seven();
      model[0] = 32'hDEAD_BE6C;
      cpu_wr(0, model[0]);
      rxpat = '0;
      rxpat[1] = 1'b1;               // received 0,1,0,0,0,0,0
      prepare(7);
      launch(7, 0);
      wait_done();
      verify(7, 0, "seven");
      cpu_addr = '0;
      #1;
      chk(cpu_rdata[7:0] == 8'h02, "R5 seven bits give 0x02", cpu_rdata[7:0], 8'h02);
      chk(cpu_rdata[31:8] == 24'hDEADBE, "R4 upper bytes kept", cpu_rdata[31:8], 24'hDEADBE);
   endtask

   task automatic t_byte();
      for (int w = 0; w < NW; w++) model[w] = 32'hF00F_1234 ^ (w << 8);
      load_all();
      rxpat = {16{32'hC3A5_0F81}};
      prepare(8);
      launch(8, 3);
      wait_done();
      verify(8, 3, "byte");
   endtask

   task automatic t_one();
      model[0] = 32'hFFFF_FFFF;
      cpu_wr(0, model[0]);
      rxpat = '0;
      prepare(1);
      launch(1, 0);
      wait_done();
      verify(1, 0, "one");
   endtask

   task automatic t_odd();
      for (int w = 0; w < NW; w++) model[w] = 32'h0123_4567 + 32'h1111_1111 * w;
      load_all();
      rxpat = {16{32'h6B2F_D019}};
      prepare(45);
      launch(45, 2);
      wait_done();
      verify(45, 2, "span45");
   endtask

   task automatic t_full();
      for (int w = 0; w < NW; w++) model[w] = ~(32'h7654_3210 * (w + 1));
      load_all();
      rxpat = {16{32'h8E4D_21B7}};
      prepare(TB);
      launch(TB, 0);
      wait_done();
      verify(TB, 0, "full");
   endtask

   task automatic t_busy_poke();
      for (int w = 0; w < NW; w++) model[w] = 32'hA0A0_0505 ^ w;
      load_all();
      rxpat = {16{32'h1357_9BDF}};
      prepare(40);
      launch(40, 2);
      repeat (10) @(negedge clk);
      start = 1'b1; xfer_len = 9'd3;
      cpu_we = 1'b1; cpu_addr = 4'd0; cpu_wdata = 32'hFFFF_FFFF;
      #1;
      chk(cpu_rdata == 32'h0, "R9 rdata zero while busy", cpu_rdata, 0);
      @(negedge clk);
      start = 1'b0; cpu_we = 1'b0; xfer_len = 9'd39;
      wait_done();
      verify(40, 2, "poke");
      repeat (20) @(negedge clk);
      chk(busy == 1'b0, "R8 no transfer after ignored start", busy, 0);
      chk(pulses == 40, "R8 pulse count unchanged", pulses, 40);
   endtask

   task automatic t_same_cycle();
      for (int w = 0; w < NW; w++) model[w] = 32'h3333_CCCC ^ (w * 7);
      load_all();
      model[0] = 32'hC3E1_5A96;
      rxpat = {16{32'hF731_0A2E}};
      prepare(12);
      @(negedge clk);
      cpu_we = 1'b1; cpu_addr = 4'd0; cpu_wdata = 32'hC3E1_5A96;
      xfer_len = 9'd11; half_div = 8'd1; start = 1'b1;
      @(negedge clk);
      cpu_we = 1'b0; start = 1'b0;
      wait_done();
      verify(12, 1, "R10 same-cycle write");
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog R7 actual=busy expected=idle");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int w = 0; w < NW; w++) model[w] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_len31();
      t_seven();
      t_byte();
      t_one();
      t_odd();
      t_full();
      t_busy_poke();
      t_same_cycle();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule